// File: doc/BRIEF.md
# 65C02 Extended Effective-Address Generator

This block produces the 16-bit effective address for the four addressing forms that the CMOS 6502 variant added or reuses for branching. It handles zero-page indirect without index, absolute indexed indirect through X, plain relative, and the dual zero-page-plus-relative form used by bit-test branches. A decoder presents a mode code, the operand bytes (`opa` is the byte after the opcode, `opb` the one after that), the X register and the address of the following instruction, then pulses `start`.

Modes that only need arithmetic finish one cycle after `start`. The two pointer modes fetch a little-endian word through a byte-wide synchronous read port with one cycle of latency. The low byte is read first, then the high byte. The result appears on `ea` together with a single-cycle `done` pulse.

The controller has four states. `S_IDLE` waits for `start`. With a pointer mode it moves to `S_REQ_LO`; with any other mode it stays in `S_IDLE` and completes directly. `S_REQ_LO` requests the low byte and always moves to `S_REQ_HI`. `S_REQ_HI` requests the high byte and captures the low byte, then always moves to `S_GET_HI`. `S_GET_HI` captures the high byte, issues `done` and always returns to `S_IDLE`.

Top module: `xea_unit`

## Requirements
- R1: After reset, `done` and `rd_req` are 0 and `ea` is 0x0000.
- R2: Mode code 0 (relative): one cycle after `start`, `done` is 1 and `ea` = `next_pc` + `opa` sign-extended, with the sum wrapping modulo 2^16. No read is issued.
- R3: Mode code 3 (zero-page and relative): one cycle after `start`, `ea` = `next_pc` + `opb` sign-extended. `opa` has no effect on `ea`, and no read is issued.
- R4: Mode code 1 (zero-page indirect): the low byte is read from {0x00, `opa`}. The high byte is read from {0x00, `opa`+1}, where the increment wraps within page zero. `ea` = {high, low}.
- R5: Mode code 2 (absolute indexed indirect): the pointer is {`opb`,`opa`} + `x`, a full 16-bit add that carries into the high byte. The low byte is read at the pointer and the high byte at pointer+1 (modulo 2^16). `ea` = {high, low}.
- R6: For a pointer mode, `rd_req` is 1 in exactly the two cycles after the edge that samples `start`, first with the low address and then with the high one. `rd_data` is taken one cycle after each request. `done` rises at the third edge after the one that sampled `start`.
- R7: `done` lasts exactly one cycle per operation. `ea` keeps its value until the next completion.
- R8: `start` is ignored while a pointer fetch is in progress. The operand inputs are captured when `start` is accepted, so changing them afterwards has no effect on the result.
- R9: Mode codes 4 to 7 are reserved. They complete one cycle after `start` with `ea` = `next_pc` and issue no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an address computation (accepted only when idle) |
| mode | input | 3 | Addressing mode code (0 rel, 1 zp indirect, 2 abs,X indirect, 3 zp+rel) |
| opa | input | 8 | First operand byte |
| opb | input | 8 | Second operand byte |
| x | input | 8 | X index register |
| next_pc | input | 16 | Address of the following instruction |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 16 | Byte read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| ea | output | 16 | Effective address |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest situation to reach is a second `start` that arrives in the middle of a pointer fetch, combined with operand inputs that change after acceptance. The bench raises `start` with a different mode and different operands in the cycle where the low byte is being requested. It then checks that the result still comes from the first operands and that no extra `done` follows. The page-zero wrap of the high pointer byte and the 16-bit carry of the indexed pointer are reached by placing the operand at 0xFF and by choosing X so that the sum crosses a page or the end of memory.

// File: rtl/xea_pkg.sv
package xea_pkg;

    localparam int unsigned MODE_W = 3;

    typedef logic [MODE_W-1:0] amode_t;

    localparam amode_t AM_REL     = 3'd0;
    localparam amode_t AM_ZPIND   = 3'd1;
    localparam amode_t AM_ABSXIND = 3'd2;
    localparam amode_t AM_ZPREL   = 3'd3;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_REQ_LO = 2'd1,
        S_REQ_HI = 2'd2,
        S_GET_HI = 2'd3
    } walk_state_t;

endpackage

// File: rtl/xea_branch.sv
module xea_branch #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] off,
    output logic [AW-1:0] target
);
    localparam int unsigned EXT_W = AW - DW;

    always_comb begin
        target = base + {{EXT_W{off[DW-1]}}, off};
    end
endmodule

// File: rtl/xea_ptr.sv
module xea_ptr #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 16
) (
    input  logic          zp,
    input  logic [DW-1:0] lo_byte,
    input  logic [DW-1:0] hi_byte,
    input  logic [DW-1:0] idx,
    output logic [AW-1:0] lo_addr,
    output logic [AW-1:0] hi_addr
);
    localparam int unsigned PAGE_W = AW - DW;

    logic [AW-1:0] indexed;
    logic [DW-1:0] zp_next;

    always_comb begin
        indexed = {hi_byte, lo_byte} + {{PAGE_W{1'b0}}, idx};
        zp_next = lo_byte + 1'b1;
        if (zp) begin
            lo_addr = {{PAGE_W{1'b0}}, lo_byte};
            hi_addr = {{PAGE_W{1'b0}}, zp_next};
        end else begin
            lo_addr = indexed;
            hi_addr = indexed + 1'b1;
        end
    end
endmodule

// File: rtl/xea_fsm.sv
module xea_fsm
    import xea_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_ptr,
    input  logic [AW-1:0] direct_ea,
    input  logic [DW-1:0] rd_data,
    output logic          load,
    output logic          rd_req,
    output logic          sel_hi,
    output logic [AW-1:0] ea,
    output logic          done
);
    walk_state_t   state, nxt;
    logic [DW-1:0] lo_q;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   nxt = (start && is_ptr) ? S_REQ_LO : S_IDLE;
            S_REQ_LO: nxt = S_REQ_HI;
            S_REQ_HI: nxt = S_GET_HI;
            S_GET_HI: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        load   = (state == S_IDLE) && start;
        rd_req = (state == S_REQ_LO) || (state == S_REQ_HI);
        sel_hi = (state == S_REQ_HI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            ea   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start && !is_ptr) begin
                        ea   <= direct_ea;
                        done <= 1'b1;
                    end
                end
                S_REQ_LO: ;
                S_REQ_HI: lo_q <= rd_data;
                S_GET_HI: begin
                    ea   <= {rd_data, lo_q};
                    done <= 1'b1;
                end
            endcase
        end
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ea_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ea));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && start) |=> (state != S_REQ_LO));

    p_req_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !sel_hi) |=> (rd_req && sel_hi));

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);
endmodule

// File: rtl/xea_unit.sv
module xea_unit
    import xea_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [MODE_W-1:0]     mode,
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic [DATA_W-1:0]     x,
    input  logic [2*DATA_W-1:0]   next_pc,
    output logic                  rd_req,
    output logic [2*DATA_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]     rd_data,
    output logic [2*DATA_W-1:0]   ea,
    output logic                  done
);
    localparam int unsigned ADDR_W = 2 * DATA_W;

    logic                mode_rel, mode_zprel, mode_zpind, mode_absx;
    logic                is_ptr, load, sel_hi;
    logic [DATA_W-1:0]   br_off;
    logic [ADDR_W-1:0]   br_target, direct_ea, lo_addr, hi_addr;
    logic                zp_q;
    logic [DATA_W-1:0]   opa_q, opb_q, x_q;

    always_comb begin
        mode_rel   = (mode == AM_REL);
        mode_zprel = (mode == AM_ZPREL);
        mode_zpind = (mode == AM_ZPIND);
        mode_absx  = (mode == AM_ABSXIND);
        is_ptr     = mode_zpind || mode_absx;
        br_off     = mode_zprel ? opb : opa;
        direct_ea  = (mode_rel || mode_zprel) ? br_target : next_pc;
    end

    xea_branch #(.DW(DATA_W), .AW(ADDR_W)) i_branch (
        .base   (next_pc),
        .off    (br_off),
        .target (br_target)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zp_q  <= 1'b0;
            opa_q <= '0;
            opb_q <= '0;
            x_q   <= '0;
        end else if (load && is_ptr) begin
            zp_q  <= mode_zpind;
            opa_q <= opa;
            opb_q <= opb;
            x_q   <= x;
        end
    end

    xea_ptr #(.DW(DATA_W), .AW(ADDR_W)) i_ptr (
        .zp      (zp_q),
        .lo_byte (opa_q),
        .hi_byte (opb_q),
        .idx     (x_q),
        .lo_addr (lo_addr),
        .hi_addr (hi_addr)
    );

    xea_fsm #(.DW(DATA_W), .AW(ADDR_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_ptr    (is_ptr),
        .direct_ea (direct_ea),
        .rd_data   (rd_data),
        .load      (load),
        .rd_req    (rd_req),
        .sel_hi    (sel_hi),
        .ea        (ea),
        .done      (done)
    );

    always_comb begin
        rd_addr = sel_hi ? hi_addr : lo_addr;
    end

    p_zp_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && zp_q) |-> (rd_addr[ADDR_W-1:DATA_W] == '0));

    p_hi_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel_hi && !zp_q) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));
endmodule

// File: tb/test_xea_unit.sv
module test_xea_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [7:0]  opa = '0, opb = '0, x = '0;
    logic [15:0] next_pc = '0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic [15:0] ea;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    xea_unit i_xea_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opa(opa), .opb(opb), .x(x), .next_pc(next_pc),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .ea(ea), .done(done)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    always @(posedge clk) if (rd_req) rd_data <= memf(rd_addr);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] xx, input logic [15:0] pc);
        @(negedge clk);
        mode = m; opa = a; opb = b; x = xx; next_pc = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // R2 / R3 / R9: single-cycle forms
    task automatic t_direct(input string req, input logic [2:0] m, input logic [7:0] a,
                            input logic [7:0] b, input logic [15:0] pc, input logic [15:0] exp);
        issue(m, a, b, 8'h00, pc);
        chk({req, " done"}, done, 1);
        chk({req, " ea"}, ea, exp);
        chk({req, " no read"}, rd_req, 0);
        @(negedge clk);
        chk({req, " R7 pulse"}, done, 0);
    endtask

    // R4 / R5 / R6: pointer forms
    task automatic t_ptr(input string req, input logic [2:0] m, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] xx,
                         input logic [15:0] lo_a, input logic [15:0] hi_a);
        logic [15:0] exp;
        exp = {memf(hi_a), memf(lo_a)};
        issue(m, a, b, xx, 16'h2222);
        chk({req, " R6 lo req"}, rd_req, 1);
        chk({req, " lo addr"}, rd_addr, lo_a);
        @(negedge clk);
        chk({req, " R6 hi req"}, rd_req, 1);
        chk({req, " hi addr"}, rd_addr, hi_a);
        chk({req, " R6 early done"}, done, 0);
        @(negedge clk);
        chk({req, " R6 req end"}, rd_req, 0);
        chk({req, " R6 early done"}, done, 0);
        @(negedge clk);
        chk({req, " R6 done"}, done, 1);
        chk({req, " ea"}, ea, exp);
        @(negedge clk);
        chk({req, " R7 pulse"}, done, 0);
    endtask

    // R8: start during a fetch, operands changed after acceptance
    task automatic t_busy_start();
        logic [15:0] exp;
        exp = {memf(16'h0041), memf(16'h0040)};
        issue(3'd1, 8'h40, 8'h00, 8'h00, 16'h1000);
        mode = 3'd0; opa = 8'h77; opb = 8'h99; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 hi addr from latched operand", rd_addr, 16'h0041);
        @(negedge clk);
        chk("R8 no early done", done, 0);
        @(negedge clk);
        chk("R8 done", done, 1);
        chk("R8 ea", ea, exp);
        @(negedge clk);
        chk("R8 no second done", done, 0);
        chk("R8 ea kept", ea, exp);
    endtask

    // R7: ea holds while idle
    task automatic t_hold();
        logic [15:0] held;
        held = ea;
        repeat (4) @(negedge clk);
        chk("R7 ea hold", ea, held);
        chk("R7 done low", done, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 rd_req", rd_req, 0);
        chk("R1 ea", ea, 16'h0000);

        t_direct("R2 fwd", 3'd0, 8'h10, 8'hEE, 16'h1234, 16'h1244);
        t_direct("R2 back", 3'd0, 8'h80, 8'h00, 16'h1000, 16'h0F80);
        t_direct("R2 wrap", 3'd0, 8'h20, 8'h00, 16'hFFF0, 16'h0010);
        t_direct("R3 fwd", 3'd3, 8'h7F, 8'h05, 16'h0300, 16'h0305);
        t_direct("R3 back", 3'd3, 8'h01, 8'hFE, 16'h0300, 16'h02FE);
        t_direct("R9 code5", 3'd5, 8'h12, 8'h34, 16'h4321, 16'h4321);
        t_direct("R9 code7", 3'd7, 8'hFF, 8'hFF, 16'h0001, 16'h0001);

        t_ptr("R4 plain", 3'd1, 8'h42, 8'hAB, 8'h33, 16'h0042, 16'h0043);
        t_ptr("R4 page wrap", 3'd1, 8'hFF, 8'h12, 8'h00, 16'h00FF, 16'h0000);
        t_ptr("R5 plain", 3'd2, 8'h00, 8'h30, 8'h04, 16'h3004, 16'h3005);
        t_ptr("R5 carry", 3'd2, 8'hFF, 8'h12, 8'h01, 16'h1300, 16'h1301);
        t_ptr("R5 top wrap", 3'd2, 8'hFE, 8'hFF, 8'h01, 16'hFFFF, 16'h0000);

        t_hold();
        t_busy_start();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule